// File: doc/BRIEF.md
# Branch Target Address Generator

This unit works out where the program counter of an 8-bit accumulator machine with a 16-bit program counter goes next after a control-transfer instruction. An external decoder presents a transfer mode, the address of the first byte of the instruction, the opcode byte, up to two operand bytes, the accumulator, the data pointer, a single condition flag (carry or a tested bit), and two byte operands for compare and decrement. The unit evaluates the branch condition and selects the target. It produces the next program counter and a taken flag. It also produces the side effects the condition instructions imply: a carry update, a decremented byte, and a bit-clear strobe.

Several target forms are covered. A relative target is the address of the following instruction plus a signed 8-bit displacement. An absolute target replaces the low 11 bits of the advanced PC. A long target is a full 16-bit address. An indirect target is the accumulator plus the data pointer. By default the outputs are registered, so a result appears one clock after its inputs are sampled. A parameter can make the outputs combinational instead. All address arithmetic wraps modulo 2^16.

Top module: `btg_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc` is 0 and `taken`, `bit_clr`, `cy_we` and `wb_we` are 0.
- R2: With the default registered outputs, every output reflects the inputs sampled at the previous rising clock edge. Before that edge, it holds the earlier result.
- R3: A relative target is `pc_in` + length + the sign-extended displacement, wrapping mod 2^16. The two-byte relative modes take the displacement from `byte1` and use length 2. These are SJMP=0, JZ=1, JNZ=2, JC=3, JNC=4 and DJNZ_R=9. The three-byte modes take the displacement from `byte2` and use length 3. These are JB=5, JNB=6, JBC=7, CJNE=8 and DJNZ_D=10.
- R4: A branch that is not taken gives `next_pc` = `pc_in` + its length with `taken`=0. Unused mode codes 14 and 15 are never taken and advance by 1.
- R5: Mode JZ (1) is taken when `acc`==0 and JNZ (2) when `acc`!=0. Mode JC (3) is taken when `flag_in`=1 and JNC (4) when `flag_in`=0. Mode JB (5) is taken when `flag_in`=1 and JNB (6) when `flag_in`=0.
- R6: Mode JBC (7) is taken only when `flag_in`=1. `bit_clr` is 1 exactly in that case.
- R7: Mode CJNE (8) is taken when `opa`!=`opb`. It always asserts `cy_we`, with `cy_val`=1 when `opa`<`opb` (unsigned) and 0 otherwise.
- R8: Modes DJNZ_R (9) and DJNZ_D (10) assert `wb_we` with `wb_val`=`opa`-1 (mod 256). They are taken only when that new value is nonzero.
- R9: Mode AJMP (11) is always taken. Its target is {(`pc_in`+2)[15:11], `opcode`[7:5], `byte1`}, so the page bits come from the advanced PC.
- R10: Mode LJMP (12) is always taken, with target {`byte1`, `byte2`}.
- R11: Mode JMPI (13) is always taken, with target `dptr` + `acc` (zero-extended), wrapping mod 2^16.
- R12: Mode SJMP (0) is always taken. A displacement of 0xFE gives a branch to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Transfer mode code from the decoder |
| pc_in | input | 16 | Address of the instruction's first byte |
| opcode | input | 8 | Opcode byte |
| byte1 | input | 8 | Second instruction byte |
| byte2 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| flag_in | input | 1 | Carry or tested bit value |
| opa | input | 8 | Compare left operand / byte to decrement |
| opb | input | 8 | Compare right operand |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | Transfer taken |
| bit_clr | output | 1 | Clear the tested bit |
| cy_we | output | 1 | Carry update strobe |
| cy_val | output | 1 | New carry value |
| wb_we | output | 1 | Decremented byte write strobe |
| wb_val | output | 8 | Decremented byte |

## Verification
The hardest case to reach is the interaction of the page-splice form with a page boundary. The upper five bits must come from the PC after it has advanced, so the difference only shows when the instruction itself straddles a 2 KB boundary. The stimulus places the instruction at 0x07FE, where the unadvanced PC would give a result in page 0. The decrement form is driven with `opa` of 1 and 0 to separate "new value zero" from "old value zero". Relative and indirect cases are driven near 0xFFFF to force wraparound.

// File: rtl/btg_pkg.sv
package btg_pkg;

   typedef enum logic [3:0] {
      XF_SJMP   = 4'd0,
      XF_JZ     = 4'd1,
      XF_JNZ    = 4'd2,
      XF_JC     = 4'd3,
      XF_JNC    = 4'd4,
      XF_JB     = 4'd5,
      XF_JNB    = 4'd6,
      XF_JBC    = 4'd7,
      XF_CJNE   = 4'd8,
      XF_DJNZ_R = 4'd9,
      XF_DJNZ_D = 4'd10,
      XF_AJMP   = 4'd11,
      XF_LJMP   = 4'd12,
      XF_JMPI   = 4'd13,
      XF_RSV14  = 4'd14,
      XF_RSV15  = 4'd15
   } xfer_e;

   typedef enum logic [1:0] {
      TS_REL  = 2'd0,
      TS_ABS  = 2'd1,
      TS_LONG = 2'd2,
      TS_IND  = 2'd3
   } tsel_e;

   typedef struct packed {
      logic taken;
      logic bit_clr;
      logic cy_we;
      logic cy_val;
      logic wb_we;
   } cond_s;

endpackage

// File: rtl/btg_cond.sv
module btg_cond
   import btg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  xfer_e              mode,
   input  logic [DATA_W-1:0]  acc,
   input  logic               flag_in,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   output cond_s              res,
   output logic [DATA_W-1:0]  wb_val
);

   logic acc_zero;
   logic ops_differ;
   logic opa_below;
   logic dec_nz;

   assign acc_zero   = (acc == '0);
   assign ops_differ = (opa != opb);
   assign opa_below  = (opa < opb);
   assign wb_val     = opa - DATA_W'(1);
   assign dec_nz     = (wb_val != '0);

   always_comb begin
      res = '0;
      unique case (mode)
         XF_SJMP, XF_AJMP, XF_LJMP, XF_JMPI: res.taken = 1'b1;
         XF_JZ:   res.taken = acc_zero;
         XF_JNZ:  res.taken = !acc_zero;
         XF_JC,
         XF_JB:   res.taken = flag_in;
         XF_JNC,
         XF_JNB:  res.taken = !flag_in;
         XF_JBC: begin
            res.taken   = flag_in;
            res.bit_clr = flag_in;
         end
         XF_CJNE: begin
            res.taken  = ops_differ;
            res.cy_we  = 1'b1;
            res.cy_val = opa_below;
         end
         XF_DJNZ_R, XF_DJNZ_D: begin
            res.taken = dec_nz;
            res.wb_we = 1'b1;
         end
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/btg_target.sv
module btg_target
   import btg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  xfer_e              mode,
   input  logic [ADDR_W-1:0]  pc_in,
   input  logic [DATA_W-1:0]  opcode,
   input  logic [DATA_W-1:0]  byte1,
   input  logic [DATA_W-1:0]  byte2,
   input  logic [DATA_W-1:0]  acc,
   input  logic [ADDR_W-1:0]  dptr,
   input  logic               taken,
   output logic [ADDR_W-1:0]  next_pc
);

   localparam int ABS_W  = DATA_W + 3;
   localparam int EXT_W  = ADDR_W - DATA_W;

   logic [1:0]         len;
   logic               disp_hi;
   tsel_e              tsel;
   logic [ADDR_W-1:0]  pc_adv;
   logic [DATA_W-1:0]  disp;
   logic [ADDR_W-1:0]  rel_tgt;
   logic [ADDR_W-1:0]  abs_tgt;
   logic [ADDR_W-1:0]  long_tgt;
   logic [ADDR_W-1:0]  ind_tgt;
   logic [ADDR_W-1:0]  tgt;

   always_comb begin
      len     = 2'd2;
      disp_hi = 1'b0;
      tsel    = TS_REL;
      unique case (mode)
         XF_SJMP, XF_JZ, XF_JNZ, XF_JC, XF_JNC, XF_DJNZ_R: len = 2'd2;
         XF_JB, XF_JNB, XF_JBC, XF_CJNE, XF_DJNZ_D: begin
            len     = 2'd3;
            disp_hi = 1'b1;
         end
         XF_AJMP: begin
            len  = 2'd2;
            tsel = TS_ABS;
         end
         XF_LJMP: begin
            len  = 2'd3;
            tsel = TS_LONG;
         end
         XF_JMPI: begin
            len  = 2'd1;
            tsel = TS_IND;
         end
         default: len = 2'd1;
      endcase
   end

   assign pc_adv  = pc_in + ADDR_W'(len);
   assign disp    = disp_hi ? byte2 : byte1;
   assign rel_tgt = pc_adv + {{EXT_W{disp[DATA_W-1]}}, disp};
   assign ind_tgt = dptr + {{EXT_W{1'b0}}, acc};

   generate
      if (ADDR_W > ABS_W) begin : g_abs_page
         assign abs_tgt = {pc_adv[ADDR_W-1:ABS_W], opcode[DATA_W-1:DATA_W-3], byte1};
      end else begin : g_abs_flat
         assign abs_tgt = {opcode[DATA_W-1:DATA_W-3], byte1};
      end
      if (ADDR_W == 2*DATA_W) begin : g_long_full
         assign long_tgt = {byte1, byte2};
      end else begin : g_long_trunc
         logic [2*DATA_W-1:0] both;
         assign both     = {byte1, byte2};
         assign long_tgt = both[ADDR_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (tsel)
         TS_ABS:  tgt = abs_tgt;
         TS_LONG: tgt = long_tgt;
         TS_IND:  tgt = ind_tgt;
         default: tgt = rel_tgt;
      endcase
   end

   assign next_pc = taken ? tgt : pc_adv;

endmodule

// File: rtl/btg_unit.sv
module btg_unit
   import btg_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        mode,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] opcode,
   input  logic [DATA_W-1:0] byte1,
   input  logic [DATA_W-1:0] byte2,
   input  logic [DATA_W-1:0] acc,
   input  logic [ADDR_W-1:0] dptr,
   input  logic              flag_in,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [ADDR_W-1:0] next_pc,
   output logic              taken,
   output logic              bit_clr,
   output logic              cy_we,
   output logic              cy_val,
   output logic              wb_we,
   output logic [DATA_W-1:0] wb_val
);

   generate
      if (DATA_W < 3) begin : g_bad_data
         $error("btg_unit: DATA_W must be at least 3");
      end
      if (ADDR_W < DATA_W + 3) begin : g_bad_addr
         $error("btg_unit: ADDR_W must hold the absolute page offset");
      end
      if (ADDR_W > 2*DATA_W) begin : g_bad_long
         $error("btg_unit: ADDR_W must not exceed two operand bytes");
      end
   endgenerate

   xfer_e             mode_e;
   cond_s             c_res;
   logic [DATA_W-1:0] c_wb;
   logic [ADDR_W-1:0] c_pc;

   assign mode_e = xfer_e'(mode);

   btg_cond #(.DATA_W(DATA_W)) u_cond (
      .mode    (mode_e),
      .acc     (acc),
      .flag_in (flag_in),
      .opa     (opa),
      .opb     (opb),
      .res     (c_res),
      .wb_val  (c_wb)
   );

   btg_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tgt (
      .mode    (mode_e),
      .pc_in   (pc_in),
      .opcode  (opcode),
      .byte1   (byte1),
      .byte2   (byte2),
      .acc     (acc),
      .dptr    (dptr),
      .taken   (c_res.taken),
      .next_pc (c_pc)
   );

   generate
      if (REG_OUT) begin : g_reg
         cond_s             q_res;
         logic [DATA_W-1:0] q_wb;
         logic [ADDR_W-1:0] q_pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_res <= '0;
               q_wb  <= '0;
               q_pc  <= '0;
            end else begin
               q_res <= c_res;
               q_wb  <= c_wb;
               q_pc  <= c_pc;
            end
         end
         assign next_pc = q_pc;
         assign taken   = q_res.taken;
         assign bit_clr = q_res.bit_clr;
         assign cy_we   = q_res.cy_we;
         assign cy_val  = q_res.cy_val;
         assign wb_we   = q_res.wb_we;
         assign wb_val  = q_wb;
      end else begin : g_comb
         assign next_pc = rst_n ? c_pc : '0;
         assign taken   = rst_n & c_res.taken;
         assign bit_clr = rst_n & c_res.bit_clr;
         assign cy_we   = rst_n & c_res.cy_we;
         assign cy_val  = rst_n & c_res.cy_val;
         assign wb_we   = rst_n & c_res.wb_we;
         assign wb_val  = rst_n ? c_wb : '0;
      end
   endgenerate

endmodule

// File: rtl/btg_chk.sv
module btg_chk #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        mode,
   input logic [ADDR_W-1:0] pc_in,
   input logic [DATA_W-1:0] opcode,
   input logic [DATA_W-1:0] byte1,
   input logic [DATA_W-1:0] byte2,
   input logic [DATA_W-1:0] acc,
   input logic [ADDR_W-1:0] dptr,
   input logic              flag_in,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [ADDR_W-1:0] next_pc,
   input logic              taken,
   input logic              bit_clr,
   input logic              cy_we,
   input logic              cy_val,
   input logic              wb_we,
   input logic [DATA_W-1:0] wb_val
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R6: a bit clear only accompanies a taken transfer
   assert_clr_needs_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_clr |-> taken);

   // R8: decrement result zero means fall through
   assert_dec_zero_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> (taken == (wb_val != '0)));

   generate
      if (REG_OUT) begin : g_seq
         assert_uncond_taken_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && ($past(mode) == 4'd0 || $past(mode) == 4'd11 ||
                         $past(mode) == 4'd12 || $past(mode) == 4'd13)) |-> taken);

         assert_indirect_sum_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(mode) == 4'd13) |->
               next_pc == $past(dptr) + {{(ADDR_W-DATA_W){1'b0}}, $past(acc)});

         assert_cmp_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(mode) == 4'd8) |->
               (cy_we && cy_val == ($past(opa) < $past(opb)) &&
                taken == ($past(opa) != $past(opb))));

         assert_long_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(mode) == 4'd12) |->
               next_pc == ADDR_W'({$past(byte1), $past(byte2)}));

         assert_zero_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(mode) == 4'd1 && !taken) |->
               next_pc == $past(pc_in) + ADDR_W'(2));
      end
   endgenerate

endmodule

bind btg_unit btg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_btg_unit.sv
module sim_btg_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  mode = '0;
   logic [15:0] pc_in = '0;
   logic [7:0]  opcode = '0;
   logic [7:0]  byte1 = '0;
   logic [7:0]  byte2 = '0;
   logic [7:0]  acc = '0;
   logic [15:0] dptr = '0;
   logic        flag_in = 1'b0;
   logic [7:0]  opa = '0;
   logic [7:0]  opb = '0;
   logic [15:0] next_pc;
   logic        taken, bit_clr, cy_we, cy_val, wb_we;
   logic [7:0]  wb_val;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   btg_unit u0 (.*);

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] m, input logic [15:0] pc,
                      input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] a, input logic [15:0] dp, input logic f,
                      input logic [7:0] x, input logic [7:0] y);
      @(negedge clk);
      mode = m; pc_in = pc; opcode = op; byte1 = b1; byte2 = b2;
      acc = a; dptr = dp; flag_in = f; opa = x; opb = y;
      @(negedge clk);
   endtask

   task automatic expect_pc(input string req, input logic [15:0] pc, input logic tk);
      check(req, "next_pc", 32'(next_pc), 32'(pc));
      check(req, "taken", 32'(taken), 32'(tk));
   endtask

   task automatic t_reset;
      #1;
      expect_pc("R1", 16'h0000, 1'b0);
      check("R1", "strobes", {28'd0, bit_clr, cy_we, wb_we, 1'b0}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_latency;
      run(4'd12, 16'h0000, 8'h02, 8'h12, 8'h34, 8'h00, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R2", 16'h1234, 1'b1);
      mode = 4'd12; byte1 = 8'h56; byte2 = 8'h78;
      #1 check("R2", "held before edge", 32'(next_pc), 32'h1234);
      @(negedge clk);
      check("R2", "after edge", 32'(next_pc), 32'h5678);
   endtask

   task automatic t_relative;
      run(4'd0, 16'h0100, 8'h80, 8'hFE, 8'h00, 8'h0, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R12", 16'h0100, 1'b1);
      run(4'd0, 16'hFFFF, 8'h80, 8'h05, 8'h00, 8'h0, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R3", 16'h0006, 1'b1);
      run(4'd5, 16'h0110, 8'h20, 8'hE2, 8'hED, 8'h0, 16'h0, 1'b1, 8'h0, 8'h0);
      expect_pc("R3", 16'h0100, 1'b1);
   endtask

   task automatic t_cond;
      run(4'd1, 16'h0200, 8'h60, 8'h10, 8'h00, 8'h00, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R5", 16'h0212, 1'b1);
      run(4'd1, 16'h0200, 8'h60, 8'h10, 8'h00, 8'h03, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R4", 16'h0202, 1'b0);
      run(4'd2, 16'h0200, 8'h70, 8'h10, 8'h00, 8'h03, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R5", 16'h0212, 1'b1);
      run(4'd3, 16'h0300, 8'h40, 8'h80, 8'h00, 8'h0, 16'h0, 1'b1, 8'h0, 8'h0);
      expect_pc("R5", 16'h0282, 1'b1);
      run(4'd4, 16'h0300, 8'h50, 8'h80, 8'h00, 8'h0, 16'h0, 1'b1, 8'h0, 8'h0);
      expect_pc("R4", 16'h0302, 1'b0);
      run(4'd6, 16'h0110, 8'h30, 8'hE2, 8'hED, 8'h0, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R5", 16'h0100, 1'b1);
      run(4'd15, 16'h0400, 8'h00, 8'h00, 8'h00, 8'h0, 16'h0, 1'b1, 8'h0, 8'h0);
      expect_pc("R4", 16'h0401, 1'b0);
   endtask

   task automatic t_bitclr;
      run(4'd7, 16'h0110, 8'h10, 8'hE2, 8'hED, 8'h0, 16'h0, 1'b1, 8'h0, 8'h0);
      expect_pc("R6", 16'h0100, 1'b1);
      check("R6", "bit_clr set", 32'(bit_clr), 32'd1);
      run(4'd7, 16'h0110, 8'h10, 8'hE2, 8'hED, 8'h0, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R6", 16'h0113, 1'b0);
      check("R6", "bit_clr clear", 32'(bit_clr), 32'd0);
   endtask

   task automatic t_compare;
      run(4'd8, 16'h0400, 8'hB8, 8'h19, 8'hFB, 8'h0, 16'h0, 1'b0, 8'h10, 8'h19);
      expect_pc("R7", 16'h03FE, 1'b1);
      check("R7", "carry below", {30'd0, cy_we, cy_val}, 32'd3);
      run(4'd8, 16'h0400, 8'hB8, 8'h19, 8'hFB, 8'h0, 16'h0, 1'b1, 8'h20, 8'h19);
      expect_pc("R7", 16'h03FE, 1'b1);
      check("R7", "carry above", {30'd0, cy_we, cy_val}, 32'd2);
      run(4'd8, 16'h0400, 8'hB8, 8'h19, 8'hFB, 8'h0, 16'h0, 1'b0, 8'h19, 8'h19);
      expect_pc("R7", 16'h0403, 1'b0);
      check("R7", "carry equal", {30'd0, cy_we, cy_val}, 32'd2);
   endtask

   task automatic t_decrement;
      run(4'd10, 16'h0110, 8'hD5, 8'h20, 8'hED, 8'h0, 16'h0, 1'b0, 8'h05, 8'h0);
      expect_pc("R8", 16'h0100, 1'b1);
      check("R8", "wb", {23'd0, wb_we, wb_val}, 32'h104);
      run(4'd10, 16'h0110, 8'hD5, 8'h20, 8'hED, 8'h0, 16'h0, 1'b0, 8'h01, 8'h0);
      expect_pc("R8", 16'h0113, 1'b0);
      check("R8", "wb zero", {23'd0, wb_we, wb_val}, 32'h100);
      run(4'd10, 16'h0110, 8'hD5, 8'h20, 8'hED, 8'h0, 16'h0, 1'b0, 8'h00, 8'h0);
      expect_pc("R8", 16'h0100, 1'b1);
      check("R8", "wb wrap", {23'd0, wb_we, wb_val}, 32'h1FF);
      run(4'd9, 16'h0500, 8'hD9, 8'hFE, 8'h00, 8'h0, 16'h0, 1'b0, 8'h02, 8'h0);
      expect_pc("R8", 16'h0500, 1'b1);
   endtask

   task automatic t_absolute;
      run(4'd11, 16'hC800, 8'hC1, 8'hC2, 8'h00, 8'h0, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R9", 16'hCEC2, 1'b1);
      run(4'd11, 16'h07FE, 8'h01, 8'h00, 8'h00, 8'h0, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R9", 16'h0800, 1'b1);
   endtask

   task automatic t_long_ind;
      run(4'd12, 16'h0102, 8'h12, 8'hAB, 8'hCD, 8'h0, 16'h0, 1'b0, 8'h0, 8'h0);
      expect_pc("R10", 16'hABCD, 1'b1);
      run(4'd13, 16'h0100, 8'h73, 8'h00, 8'h00, 8'h12, 16'h0130, 1'b0, 8'h0, 8'h0);
      expect_pc("R11", 16'h0142, 1'b1);
      run(4'd13, 16'h0100, 8'h73, 8'h00, 8'h00, 8'hFF, 16'hFFF0, 1'b0, 8'h0, 8'h0);
      expect_pc("R11", 16'h00EF, 1'b1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_relative();
      t_cond();
      t_bitclr();
      t_compare();
      t_decrement();
      t_absolute();
      t_long_ind();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule